// File: doc/BRIEF.md
# Write-Masked PHY Configuration Port

This block is a small register slave that sits between a system register bus and the configuration port of a serial PHY. Every register write carries its own bit-enable mask in the upper half of the 32-bit data word: a lower bit is updated only when its partner bit sixteen places higher is set in the same write. A single read-modify-write is therefore never needed, and several agents can own separate bits of one register.

The configuration register packs a PHY-internal address field, a small data field and a write strobe level. Software performs an indirect PHY write in three steps: it places the address and data, sets the strobe, and rewrites the strobe. The block turns a low-to-high change of the stored strobe into a single-cycle write pulse toward the PHY, so a repeated write of the same level is harmless. For an indirect read, software writes the address with a wider mask that also clears the data field, then reads the status register. That register returns the PHY's readback bits together with the PLL lock and PLL output flags. A second masked register holds one idle-request bit per lane.

Requests are accepted on every cycle. A read answers with a response pulse and data one cycle later.

Top module: `phy_cfg_port`

## Requirements
- R1: On an accepted write to a masked register, lower bit x takes write-data bit x when write-data bit x+16 is 1. Otherwise it keeps its previous value.
- R2: A read of the configuration or lane register returns the stored 16 bits in [15:0], and bits [31:16] read as zero.
- R3: The PHY address output equals configuration bits [6:1], and the PHY data output equals configuration bits [10:7].
- R4: When configuration bit 0 changes from 0 to 1, the PHY write pulse is high for exactly the one cycle after that write. A write that leaves bit 0 at 1 produces no pulse, and neither does a write that clears it.
- R5: A status read returns the PHY readback in bits [8:0], the PLL-locked flag in bit 9 and the PLL-output flag in bit 10. Bits [31:11] are zero.
- R6: After reset both masked registers read zero, and the PHY address, data, write pulse and lane outputs are all zero.
- R7: Lane idle output i equals lane-register bit 3+i, for lanes 0 to 3.
- R8: The response valid is high in the cycle after an accepted read and low after a write. The response data belongs to that read.
- R9: A write to the status offset (0x08) or to an unmapped offset changes neither masked register. The configuration register is at offset 0x00 and the lane register at 0x04.
- R10: A write with mask 0x07FE sets the address field, clears the data field and leaves the strobe bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Request accepted (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Register byte offset |
| req_wdata | input | 32 | Mask in [31:16], value in [15:0] |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| phy_cfg_addr | output | 6 | PHY-internal configuration address |
| phy_cfg_data | output | 4 | PHY-internal configuration write data |
| phy_cfg_wr | output | 1 | Single-cycle PHY configuration write pulse |
| phy_rd_data | input | 9 | PHY configuration readback |
| phy_pll_locked | input | 1 | PLL lock flag from the PHY |
| phy_pll_out | input | 1 | PLL output state flag from the PHY |
| lane_idle | output | 4 | Per-lane idle request |

## Verification
The assertions check on every cycle that masked bits hold and enabled bits load, that an idle cycle leaves the registers untouched, and that the write pulse never lasts two cycles and only follows a rising strobe level. They also check that a response follows exactly the accepted reads and that masked reads carry a zero upper half. The field placement toward the PHY, the status bit packing, the lane mapping and the harmlessness of writes to the status and unmapped offsets are shown only by the bench. It runs directed sequences and seeded random writes and reads against its own bit-by-bit register model.

// File: rtl/phy_cfg_pkg.sv
`timescale 1ns/1ps
package phy_cfg_pkg;
  localparam int WORD_W = 32;
  localparam int HALF_W = 16;

  typedef logic [HALF_W-1:0] half_t;
  typedef logic [WORD_W-1:0] word_t;

  // Per-bit enabled merge: the upper half of the write word enables the lower half.
  function automatic half_t wmask_merge(input half_t old_val, input word_t wr);
    half_t en;
    en = wr[WORD_W-1:HALF_W];
    return (old_val & ~en) | (wr[HALF_W-1:0] & en);
  endfunction

  // Masked registers read back with a zero upper half.
  function automatic word_t widen_half(input half_t v);
    return {{(WORD_W-HALF_W){1'b0}}, v};
  endfunction
endpackage

// File: rtl/masked_reg.sv
`timescale 1ns/1ps
module masked_reg
  import phy_cfg_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  we,
  input  word_t wdata,
  output half_t q
);
  half_t q_r;

  always_ff @(posedge clk) begin
    if (!rst_n)  q_r <= '0;
    else if (we) q_r <= wmask_merge(q_r, wdata);
  end

  assign q = q_r;

  // R1: bits whose enable was clear keep their value
  a_r1_masked_hold: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (((q ^ $past(q)) & ~$past(wdata[WORD_W-1:HALF_W])) == '0));
  // R1: bits whose enable was set take the written value
  a_r1_enabled_load: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (((q ^ $past(wdata[HALF_W-1:0])) & $past(wdata[WORD_W-1:HALF_W])) == '0));
  // R9: no write enable, no change
  a_r9_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(q));
endmodule

// File: rtl/strobe_edge.sv
`timescale 1ns/1ps
module strobe_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic pulse
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= level;
  end

  assign pulse = level & ~prev_q;

  // R4: the pulse never spans two cycles
  a_r4_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse);
  // R4: a pulse only follows a level that was low one cycle earlier
  a_r4_from_rise: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> (level && !$past(level)));
endmodule

// File: rtl/phy_cfg_port.sv
`timescale 1ns/1ps
module phy_cfg_port
  import phy_cfg_pkg::*;
#(
  parameter int AW          = 8,
  parameter int CFG_ADDR_W  = 6,
  parameter int CFG_DATA_W  = 4,
  parameter int RDBK_W      = 9,
  parameter int NUM_LANES   = 4,
  parameter int LANE_SHIFT  = 3,
  parameter logic [AW-1:0] CFG_OFS  = 8'h00,
  parameter logic [AW-1:0] LANE_OFS = 8'h04,
  parameter logic [AW-1:0] STAT_OFS = 8'h08
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic [AW-1:0]         req_addr,
  input  logic [31:0]           req_wdata,
  output logic                  rsp_valid,
  output logic [31:0]           rsp_rdata,
  output logic [CFG_ADDR_W-1:0] phy_cfg_addr,
  output logic [CFG_DATA_W-1:0] phy_cfg_data,
  output logic                  phy_cfg_wr,
  input  logic [RDBK_W-1:0]     phy_rd_data,
  input  logic                  phy_pll_locked,
  input  logic                  phy_pll_out,
  output logic [NUM_LANES-1:0]  lane_idle
);
  localparam int STROBE_BIT   = 0;
  localparam int ADDR_LSB     = STROBE_BIT + 1;
  localparam int DATA_LSB     = ADDR_LSB + CFG_ADDR_W;
  localparam int LOCK_BIT     = RDBK_W;
  localparam int PLLOUT_BIT   = RDBK_W + 1;
  localparam int STAT_USED    = PLLOUT_BIT + 1;

  // Status packing: readback low, then lock flag, then PLL output flag.
  function automatic word_t pack_status(input logic [RDBK_W-1:0] rd,
                                        input logic lock, input logic pout);
    return {{(WORD_W-STAT_USED){1'b0}}, pout, lock, rd};
  endfunction

  // Request decode
  logic hit_cfg, hit_lane, hit_stat;
  logic wr_fire, rd_fire, cfg_we, lane_we;

  assign req_ready = 1'b1;
  assign hit_cfg   = (req_addr == CFG_OFS);
  assign hit_lane  = (req_addr == LANE_OFS);
  assign hit_stat  = (req_addr == STAT_OFS);
  assign wr_fire   = req_valid & req_ready & req_write;
  assign rd_fire   = req_valid & req_ready & ~req_write;
  assign cfg_we    = wr_fire & hit_cfg;
  assign lane_we   = wr_fire & hit_lane;

  // Masked registers
  half_t cfg_q, lane_q;

  masked_reg u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .wdata (req_wdata),
    .q     (cfg_q)
  );

  masked_reg u_lane (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (lane_we),
    .wdata (req_wdata),
    .q     (lane_q)
  );

  // PHY configuration port
  assign phy_cfg_addr = cfg_q[ADDR_LSB +: CFG_ADDR_W];
  assign phy_cfg_data = cfg_q[DATA_LSB +: CFG_DATA_W];

  logic strobe_level;
  assign strobe_level = cfg_q[STROBE_BIT];

  strobe_edge u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .level (strobe_level),
    .pulse (phy_cfg_wr)
  );

  // Lane idle mapping
  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    assign lane_idle[i] = lane_q[LANE_SHIFT + i];
  end

  // Read path
  word_t rd_mux;
  always_comb begin
    rd_mux = '0;
    if (hit_cfg)       rd_mux = widen_half(cfg_q);
    else if (hit_lane) rd_mux = widen_half(lane_q);
    else if (hit_stat) rd_mux = pack_status(phy_rd_data, phy_pll_locked, phy_pll_out);
  end

  logic  rsp_valid_q;
  word_t rsp_rdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      rsp_valid_q <= rd_fire;
      if (rd_fire) rsp_rdata_q <= rd_mux;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rsp_rdata_q;

  // R8: every accepted read is answered on the next cycle
  a_r8_rsp_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> rsp_valid);
  // R8: no response without a read one cycle earlier
  a_r8_rsp_only_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && !req_write));
  // R2: masked register reads carry a zero upper half
  a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(hit_cfg || hit_lane)) |-> (rsp_rdata[31:16] == 16'h0000));
endmodule

// File: tb/sim_phy_cfg_port.sv
`timescale 1ns/1ps
module sim_phy_cfg_port;
  localparam logic [7:0] A_CFG  = 8'h00;
  localparam logic [7:0] A_LANE = 8'h04;
  localparam logic [7:0] A_STAT = 8'h08;
  localparam logic [7:0] A_NONE = 8'h0C;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic        req_ready;
  logic [7:0]  req_addr;
  logic [31:0] req_wdata;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic [5:0]  phy_cfg_addr;
  logic [3:0]  phy_cfg_data;
  logic        phy_cfg_wr;
  logic [8:0]  phy_rd_data;
  logic        phy_pll_locked, phy_pll_out;
  logic [3:0]  lane_idle;

  always #5 clk = ~clk;

  phy_cfg_port u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .phy_cfg_addr(phy_cfg_addr), .phy_cfg_data(phy_cfg_data), .phy_cfg_wr(phy_cfg_wr),
    .phy_rd_data(phy_rd_data), .phy_pll_locked(phy_pll_locked), .phy_pll_out(phy_pll_out),
    .lane_idle(lane_idle)
  );

  int errs = 0;
  int checks = 0;
  logic [15:0] m_cfg, m_lane;

  // Bench model: walk the bits one at a time.
  function automatic logic [15:0] ref_merge(input logic [15:0] old_v, input logic [31:0] w);
    logic [15:0] r;
    r = old_v;
    for (int b = 0; b < 16; b++) if (w[16+b]) r[b] = w[b];
    return r;
  endfunction

  function automatic logic [31:0] ref_status(input logic [8:0] rd, input logic lk, input logic po);
    logic [31:0] s;
    s = 32'h0;
    s[8:0] = rd;
    s[9]   = lk;
    s[10]  = po;
    return s;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    logic exp_pulse;
    exp_pulse = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    if (a == A_CFG) begin
      logic [15:0] nv;
      nv = ref_merge(m_cfg, d);
      exp_pulse = !m_cfg[0] && nv[0];
      m_cfg = nv;
    end else if (a == A_LANE) begin
      m_lane = ref_merge(m_lane, d);
    end
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    chk(phy_cfg_addr == m_cfg[6:1], "R3 addr field", {26'h0, phy_cfg_addr}, {26'h0, m_cfg[6:1]});
    chk(phy_cfg_data == m_cfg[10:7], "R3 data field", {28'h0, phy_cfg_data}, {28'h0, m_cfg[10:7]});
    chk(lane_idle == m_lane[6:3], "R7 lane idle", {28'h0, lane_idle}, {28'h0, m_lane[6:3]});
    chk(phy_cfg_wr == exp_pulse, "R4 pulse after write", {31'h0, phy_cfg_wr}, {31'h0, exp_pulse});
    chk(rsp_valid == 1'b0, "R8 no response to write", {31'h0, rsp_valid}, 32'h0);
    @(negedge clk);
    chk(phy_cfg_wr == 1'b0, "R4 pulse one cycle", {31'h0, phy_cfg_wr}, 32'h0);
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_wdata = $urandom;
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid == 1'b1, "R8 response valid", {31'h0, rsp_valid}, 32'h1);
    chk(rsp_rdata == exp, tag, rsp_rdata, exp);
  endtask

  initial begin
    #2000000;
    errs++;
    $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    phy_rd_data = '0; phy_pll_locked = 1'b0; phy_pll_out = 1'b0;
    m_cfg = '0; m_lane = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R6 reset state
    chk(phy_cfg_addr == 0 && phy_cfg_data == 0, "R6 phy fields zero",
        {22'h0, phy_cfg_data, phy_cfg_addr}, 32'h0);
    chk(phy_cfg_wr == 1'b0, "R6 no pulse", {31'h0, phy_cfg_wr}, 32'h0);
    chk(lane_idle == 4'h0, "R6 lanes zero", {28'h0, lane_idle}, 32'h0);
    rd(A_CFG,  32'h0, "R6 cfg reads zero");
    rd(A_LANE, 32'h0, "R6 lane reads zero");

    // R3 and R4: the three-step indirect write
    wr(A_CFG, {16'h07FE, 5'h0, 4'h8, 6'h10, 1'b0});
    wr(A_CFG, 32'h0001_0001);
    wr(A_CFG, 32'h0001_0001);
    rd(A_CFG, {16'h0, m_cfg}, "R2 cfg readback");
    wr(A_CFG, 32'h0001_0000);
    wr(A_CFG, {16'h07FF, 5'h0, 4'h8, 6'h12, 1'b1});

    // R10 read-address write with the wide mask
    wr(A_CFG, {16'h07FE, 5'h0, 4'h0, 6'h21, 1'b0});
    chk(phy_cfg_data == 4'h0, "R10 data cleared", {28'h0, phy_cfg_data}, 32'h0);
    chk(phy_cfg_addr == 6'h21, "R10 addr set", {26'h0, phy_cfg_addr}, 32'h21);
    rd(A_CFG, {16'h0, m_cfg}, "R10 strobe kept");

    // R1 upper garbage without enable is ignored
    wr(A_CFG, 32'h0000_FFFF);
    rd(A_CFG, {16'h0, m_cfg}, "R1 no enable no change");

    // R5 status patterns
    phy_rd_data = 9'h1A5; phy_pll_locked = 1'b1; phy_pll_out = 1'b0;
    rd(A_STAT, ref_status(9'h1A5, 1'b1, 1'b0), "R5 status lock");
    phy_rd_data = 9'h05A; phy_pll_locked = 1'b0; phy_pll_out = 1'b1;
    rd(A_STAT, ref_status(9'h05A, 1'b0, 1'b1), "R5 status pll out");

    // R7 each lane bit
    for (int i = 0; i < 4; i++) begin
      wr(A_LANE, 32'h0078_0000 | (32'h8 << i));
      chk(lane_idle == (4'h1 << i), "R7 single lane", {28'h0, lane_idle}, {28'h0, 4'h1 << i});
    end

    // R9 writes to status and unmapped offsets
    wr(A_STAT, 32'hFFFF_FFFF);
    wr(A_NONE, 32'hFFFF_FFFF);
    rd(A_CFG,  {16'h0, m_cfg},  "R9 cfg untouched");
    rd(A_LANE, {16'h0, m_lane}, "R9 lane untouched");
    rd(A_NONE, 32'h0, "R9 unmapped reads zero");

    // Random mix
    for (int n = 0; n < 400; n++) begin
      logic [31:0] r;
      r = $urandom;
      case (r[2:0])
        3'd0, 3'd1, 3'd2: wr(A_CFG, $urandom);
        3'd3, 3'd4:       wr(A_LANE, $urandom);
        3'd5:             rd(A_CFG, {16'h0, m_cfg}, "R1 random cfg");
        3'd6:             rd(A_LANE, {16'h0, m_lane}, "R1 random lane");
        default: begin
          phy_rd_data = r[16:8]; phy_pll_locked = r[20]; phy_pll_out = r[21];
          rd(A_STAT, ref_status(r[16:8], r[20], r[21]), "R5 random status");
        end
      endcase
    end

    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule